// File: doc/BRIEF.md
# Programmable Input Debounce Filter

This block cleans up one general-purpose input pin before the pin's status and interrupt logic sees it. The raw pin first passes through a two-flop synchronizer into the fast system clock domain. A filter then decides when the registered output may follow the synchronized level. The time base is a single-cycle tick enable, produced elsewhere from a slow real-time clock of roughly 32.768 kHz. The output moves only after the input has held steady for a programmed number of those ticks.

Software sets four fields. A 4-bit count is the number of units the input must stay stable. Two range bits set the length of one unit in ticks. A 2-bit type field picks the filter behaviour: pass-through, filtering of changes in both directions, or filtering of only one direction. In the one-direction types, changes in the other direction reach the output at once.

Edge-triggered interrupt use normally selects the both-directions type. Active-high level use selects the type that delays only rising changes. Active-low level use selects the type that delays only falling changes.

Top module: `gpio_debounce`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pin_filt` is 0 after that edge.
- R2: With `flt_type` = 0 (pass-through) and the configuration unchanged, a change of `pin_raw` appears on `pin_filt` after the third rising clock edge that follows it. The first two edges fill the synchronizer.
- R3: One unit is selected by {`rng_large`, `rng_unit`}: 00 gives 2 ticks, 01 gives 8, 10 gives 512 and 11 gives 2048.
- R4: A filtered change reaches `pin_filt` on the clock edge where the synchronized input has been seen different from the output on N ticks in a row. N = `hold_cnt` × unit. A `hold_cnt` of 0 counts as 1.
- R5: With `flt_type` = 1, both rising and falling changes are filtered. A pulse that lasts fewer than N ticks never reaches `pin_filt`.
- R6: With `flt_type` = 2, rising changes are filtered and falling changes pass with the pass-through latency of R2.
- R7: With `flt_type` = 3, falling changes are filtered and rising changes pass with the pass-through latency of R2.
- R8: When the synchronized input returns to the output level before N ticks have been counted, the count restarts from zero. A later change needs a full N ticks.
- R9: Only clock cycles with `rtc_tick` high advance the count. Without ticks, a filtered change never reaches `pin_filt`.
- R10: On a cycle where any configuration field differs from its value in the previous cycle, `pin_filt` keeps its value and the count restarts. The reset value of every field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rtc_tick | input | 1 | One-cycle enable marking a slow time-base tick |
| pin_raw | input | 1 | Asynchronous pin level |
| hold_cnt | input | 4 | Number of units the input must stay stable |
| rng_unit | input | 1 | Low bit of the unit select |
| rng_large | input | 1 | High bit of the unit select |
| flt_type | input | 2 | 0 pass-through, 1 both directions, 2 delay rising only, 3 delay falling only |
| pin_filt | output | 1 | Filtered pin level |

## Verification
If the stability count is corrupted, a filtered change shows up on `pin_filt` early or late by whole ticks. This is visible on the first transition after the fault. If the restart logic is wrong, a short glitch followed by a return to the old level moves the output within one window that should have stayed quiet. A wrong direction decode in a one-sided type shows up within three clock edges: the unfiltered direction either fails to pass, or it waits a full window. A configuration change that fails to hold the output shows up on the very next edge.

// File: rtl/gpio_debounce_pkg.sv
// Package: shared types and helpers for the pin debounce filter.
// Assumes the unit-select code is {large, unit}, two bits wide.
package gpio_debounce_pkg;

    typedef enum logic [1:0] {
        FLT_PASS      = 2'd0,
        FLT_BOTH      = 2'd1,
        FLT_RISE_ONLY = 2'd2,
        FLT_FALL_ONLY = 2'd3
    } flt_type_e;

    // Length of one unit in ticks for a given select code.
    function automatic int unsigned unit_len(input logic [1:0] sel,
                                             input int unsigned u0,
                                             input int unsigned u1,
                                             input int unsigned u2,
                                             input int unsigned u3);
        case (sel)
            2'd0:    return u0;
            2'd1:    return u1;
            2'd2:    return u2;
            default: return u3;
        endcase
    endfunction

endpackage

// File: rtl/gpio_debounce_sync.sv
// Module: multi-flop synchronizer for an asynchronous level.
// Assumes STAGES >= 2 and a synchronous active-low reset to 0.
module gpio_debounce_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_debounce_policy.sv
// Module: decides, per filter type, whether a difference between the
// synchronized input and the output is filtered (must wait) or passes now.
// Pure combinational; assumes the caller holds the output on config change.
module gpio_debounce_policy
    import gpio_debounce_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       s_in,
    input  logic       f_out,
    output logic       pend,
    output logic       pass_now
);

    logic differ;
    assign differ = s_in ^ f_out;

    // Split a difference into the filtered and the immediate direction.
    always_comb begin
        pend     = 1'b0;
        pass_now = 1'b0;
        case (flt_type_e'(mode))
            FLT_PASS:      pass_now = differ;
            FLT_BOTH:      pend     = differ;
            FLT_RISE_ONLY: begin
                pend     = differ &  s_in;
                pass_now = differ & ~s_in;
            end
            default: begin
                pend     = differ & ~s_in;
                pass_now = differ &  s_in;
            end
        endcase
    end

endmodule

// File: rtl/gpio_debounce_timer.sv
// Module: stability window counter. Counts ticks while 'run' is high and
// signals 'done' on the tick that completes count x unit ticks.
// Assumes the caller drops 'run' whenever the window must restart.
module gpio_debounce_timer
    import gpio_debounce_pkg::*;
#(
    parameter int          CNT_W  = 4,
    parameter int          ACC_W  = 15,
    parameter int unsigned UNIT_0 = 2,
    parameter int unsigned UNIT_1 = 8,
    parameter int unsigned UNIT_2 = 512,
    parameter int unsigned UNIT_3 = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  logic [1:0]       sel,
    output logic             done
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] tgt;
    logic [CNT_W-1:0] cnt_eff;

    // A zero count is treated as a single unit.
    assign cnt_eff = (count == '0) ? CNT_W'(1) : count;
    assign tgt     = ACC_W'(32'(cnt_eff) * unit_len(sel, UNIT_0, UNIT_1, UNIT_2, UNIT_3));
    assign done    = run & tick & (acc_q == tgt - ACC_W'(1));

    // Accumulate ticks; clear on restart or on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)            acc_q <= '0;
        else if (!run || done) acc_q <= '0;
        else if (tick)         acc_q <= acc_q + ACC_W'(1);
    end

    // R4: while counting, the accumulator never reaches the window length
    p_acc_below_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (acc_q < tgt));

endmodule

// File: rtl/gpio_debounce.sv
// Module: per-pin programmable debounce filter (top).
// Synchronizes the pin, tracks configuration changes, and updates the
// filtered level either at once or after a tick-counted stability window.
// Assumes rtc_tick is a single-cycle pulse in the clk domain.
module gpio_debounce
    import gpio_debounce_pkg::*;
#(
    parameter int          CNT_W     = 4,
    parameter int          SYNC_DEPTH = 2,
    parameter int unsigned UNIT_0    = 2,
    parameter int unsigned UNIT_1    = 8,
    parameter int unsigned UNIT_2    = 512,
    parameter int unsigned UNIT_3    = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rtc_tick,
    input  logic             pin_raw,
    input  logic [CNT_W-1:0] hold_cnt,
    input  logic             rng_unit,
    input  logic             rng_large,
    input  logic [1:0]       flt_type,
    output logic             pin_filt
);

    localparam int ACC_W = $clog2(((1 << CNT_W) - 1) * UNIT_3 + 1);
    localparam int CFG_W = CNT_W + 4;

    logic             s_sync;
    logic             filt_q;
    logic [CFG_W-1:0] cfg_now;
    logic [CFG_W-1:0] cfg_q;
    logic             cfg_chg;
    logic             pend;
    logic             pass_now;
    logic             win_run;
    logic             win_done;

    gpio_debounce_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_raw),
        .q_sync  (s_sync)
    );

    assign cfg_now = {hold_cnt, rng_large, rng_unit, flt_type};
    assign cfg_chg = (cfg_now != cfg_q);

    // Remember last cycle's configuration to detect changes.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_now;
    end

    gpio_debounce_policy u_policy (
        .mode     (flt_type),
        .s_in     (s_sync),
        .f_out    (filt_q),
        .pend     (pend),
        .pass_now (pass_now)
    );

    assign win_run = pend & ~cfg_chg;

    gpio_debounce_timer #(
        .CNT_W  (CNT_W),
        .ACC_W  (ACC_W),
        .UNIT_0 (UNIT_0),
        .UNIT_1 (UNIT_1),
        .UNIT_2 (UNIT_2),
        .UNIT_3 (UNIT_3)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (win_run),
        .tick  (rtc_tick),
        .count (hold_cnt),
        .sel   ({rng_large, rng_unit}),
        .done  (win_done)
    );

    // Update the filtered level on an immediate pass or a completed window.
    always_ff @(posedge clk) begin
        if (!rst_n)                                filt_q <= 1'b0;
        else if (!cfg_chg && (pass_now || win_done)) filt_q <= s_sync;
    end

    assign pin_filt = filt_q;

    // R10: a configuration change holds the output for that cycle
    p_cfg_change_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (filt_q == $past(filt_q)));

    // R2: pass-through follows the synchronized input one edge later
    p_pass_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_type == FLT_PASS && !cfg_chg) |=> (filt_q == $past(s_sync)));

    // R5: in both-direction mode the output moves only on a completed window
    p_both_waits_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_type == FLT_BOTH && !cfg_chg && !win_done) |=> $stable(filt_q));

    // R6: falling changes pass at once when only rising ones are delayed
    p_rise_only_fall_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_type == FLT_RISE_ONLY && !cfg_chg && filt_q && !s_sync) |=> !filt_q);

    // R7: rising changes pass at once when only falling ones are delayed
    p_fall_only_rise_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_type == FLT_FALL_ONLY && !cfg_chg && !filt_q && s_sync) |=> filt_q);

endmodule

// File: tb/tb_gpio_debounce.sv
// Bench: directed corner cases plus seeded random stimulus, checked
// against a cycle model built from the requirements.
module tb_gpio_debounce;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rtc_tick = 1'b0;
    logic       pin_raw = 1'b0;
    logic [3:0] hold_cnt = 4'd0;
    logic       rng_unit = 1'b0;
    logic       rng_large = 1'b0;
    logic [1:0] flt_type = 2'd0;
    logic       pin_filt;

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";
    bit    cmp_en = 1'b0;
    bit    done_all = 1'b0;

    always #4 clk = ~clk;

    gpio_debounce dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rtc_tick  (rtc_tick),
        .pin_raw   (pin_raw),
        .hold_cnt  (hold_cnt),
        .rng_unit  (rng_unit),
        .rng_large (rng_large),
        .flt_type  (flt_type),
        .pin_filt  (pin_filt)
    );

    // R3/R4: window length in ticks from count and unit select
    function automatic int window_ticks(input logic [3:0] c, input logic [1:0] sel);
        int u;
        case (sel)
            2'd0: u = 2;
            2'd1: u = 8;
            2'd2: u = 512;
            default: u = 2048;
        endcase
        return ((c == 4'd0) ? 1 : int'(c)) * u;
    endfunction

    task automatic chk(input logic exp, input string req);
        checks++;
        if (pin_filt !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, pin_filt, exp, $time);
        end
    endtask

    // Reference model state
    logic       m_s1, m_s2, m_out;
    int         m_acc;
    logic [7:0] m_cfg;

    always @(posedge clk) begin
        logic [7:0] cn;
        logic chg, diff, pend, imm;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_out = 0; m_acc = 0; m_cfg = 0;
        end else begin
            cn   = {hold_cnt, rng_large, rng_unit, flt_type};
            chg  = (cn != m_cfg);
            diff = (m_s2 != m_out);
            case (flt_type)
                2'd0: begin pend = 0;            imm = diff;         end
                2'd1: begin pend = diff;         imm = 0;            end
                2'd2: begin pend = diff & m_s2;  imm = diff & !m_s2; end
                default: begin pend = diff & !m_s2; imm = diff & m_s2; end
            endcase
            if (chg) m_acc = 0;
            else if (imm) begin m_out = m_s2; m_acc = 0; end
            else if (pend) begin
                if (rtc_tick) begin
                    if (m_acc + 1 == window_ticks(hold_cnt, {rng_large, rng_unit})) begin
                        m_out = m_s2; m_acc = 0;
                    end else m_acc = m_acc + 1;
                end
            end else m_acc = 0;
            m_cfg = cn;
            m_s2 = m_s1;
            m_s1 = pin_raw;
        end
    end

    // Continuous comparison with the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cmp_en) chk(m_out, cur_req);
    end

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Bring the output to a known level through pass-through mode.
    task automatic prep(input logic lvl, input logic [1:0] ty, input logic [3:0] c,
                        input logic [1:0] sel, input logic tk);
        flt_type = 2'd0; rtc_tick = 1'b0; pin_raw = lvl;
        edges(6);
        flt_type = ty; hold_cnt = c; {rng_large, rng_unit} = sel; rtc_tick = tk;
        edges(2);
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        @(negedge clk);
        rst_n = 1'b0;
        edges(4);
        cur_req = "R1";
        chk(1'b0, "R1");
        rst_n = 1'b1;
        cmp_en = 1'b1;
        edges(3);

        // R2 pass-through latency
        cur_req = "R2";
        pin_raw = 1'b1; edges(2); chk(1'b0, "R2"); edges(1); chk(1'b1, "R2");
        pin_raw = 1'b0; edges(2); chk(1'b1, "R2"); edges(1); chk(1'b0, "R2");

        // R4 zero count behaves as one unit of 2 ticks
        cur_req = "R4";
        prep(1'b0, 2'd1, 4'd0, 2'b00, 1'b1);
        pin_raw = 1'b1; edges(3); chk(1'b0, "R4"); edges(1); chk(1'b1, "R4");

        // R3 unit 8, count 3 -> 24 ticks
        cur_req = "R3";
        prep(1'b0, 2'd1, 4'd3, 2'b01, 1'b1);
        pin_raw = 1'b1; edges(25); chk(1'b0, "R3"); edges(1); chk(1'b1, "R3");
        // R3 unit 512, count 1
        prep(1'b0, 2'd1, 4'd1, 2'b10, 1'b1);
        pin_raw = 1'b1; edges(513); chk(1'b0, "R3"); edges(1); chk(1'b1, "R3");
        // R3 unit 2048, count 0
        prep(1'b0, 2'd1, 4'd0, 2'b11, 1'b1);
        pin_raw = 1'b1; edges(2049); chk(1'b0, "R3"); edges(1); chk(1'b1, "R3");

        // R5 short pulse rejected, then both directions delayed (4 ticks)
        cur_req = "R5";
        prep(1'b0, 2'd1, 4'd2, 2'b00, 1'b1);
        pin_raw = 1'b1; edges(3); pin_raw = 1'b0; edges(10); chk(1'b0, "R5");
        pin_raw = 1'b1; edges(5); chk(1'b0, "R5"); edges(1); chk(1'b1, "R5");
        pin_raw = 1'b0; edges(5); chk(1'b1, "R5"); edges(1); chk(1'b0, "R5");

        // R8 restart after a return to the output level
        cur_req = "R8";
        prep(1'b0, 2'd1, 4'd2, 2'b00, 1'b1);
        pin_raw = 1'b1; edges(3); pin_raw = 1'b0; edges(1); pin_raw = 1'b1;
        edges(3); chk(1'b0, "R8"); edges(5); chk(1'b1, "R8");

        // R6 rising delayed, falling immediate
        cur_req = "R6";
        prep(1'b0, 2'd2, 4'd2, 2'b00, 1'b1);
        pin_raw = 1'b1; edges(5); chk(1'b0, "R6"); edges(1); chk(1'b1, "R6");
        pin_raw = 1'b0; edges(2); chk(1'b1, "R6"); edges(1); chk(1'b0, "R6");

        // R7 falling delayed, rising immediate
        cur_req = "R7";
        prep(1'b1, 2'd3, 4'd2, 2'b00, 1'b1);
        pin_raw = 1'b0; edges(5); chk(1'b1, "R7"); edges(1); chk(1'b0, "R7");
        pin_raw = 1'b1; edges(2); chk(1'b0, "R7"); edges(1); chk(1'b1, "R7");

        // R9 no ticks, no filtered change
        cur_req = "R9";
        prep(1'b0, 2'd1, 4'd1, 2'b00, 1'b0);
        pin_raw = 1'b1; edges(200); chk(1'b0, "R9");
        rtc_tick = 1'b1; edges(1); chk(1'b0, "R9"); edges(1); chk(1'b1, "R9");

        // R10 config change restarts the window and holds the output
        cur_req = "R10";
        prep(1'b0, 2'd1, 4'd2, 2'b00, 1'b1);
        pin_raw = 1'b1; edges(3); hold_cnt = 4'd3;
        edges(6); chk(1'b0, "R10"); edges(1); chk(1'b1, "R10");
        prep(1'b0, 2'd1, 4'd1, 2'b00, 1'b0);
        pin_raw = 1'b1; edges(10); chk(1'b0, "R10");
        flt_type = 2'd0; edges(0); chk(1'b0, "R10"); edges(1); chk(1'b1, "R10");

        // Random segments against the model
        cur_req = "R4";
        for (int seg = 0; seg < 40; seg++) begin
            int dens, pinp, pk;
            hold_cnt  = 4'($urandom_range(0, 15));
            rng_unit  = 1'($urandom_range(0, 1));
            rng_large = 1'b0;
            flt_type  = 2'($urandom_range(0, 3));
            dens = int'($urandom_range(1, 4));
            pk   = int'($urandom_range(0, 2));
            pinp = (pk == 0) ? 3 : ((pk == 1) ? 30 : 300);
            for (int c = 0; c < 600; c++) begin
                @(negedge clk);
                rtc_tick = ($urandom_range(1, dens) == 1);
                if ($urandom_range(1, pinp) == 1) pin_raw = ~pin_raw;
                if ($urandom_range(1, 400) == 1) flt_type = 2'($urandom_range(0, 3));
            end
        end
        cur_req = "R3";
        hold_cnt = 4'd1; rng_large = 1'b1; rng_unit = 1'b1; flt_type = 2'd1;
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            rtc_tick = 1'b1;
            if ($urandom_range(1, 2500) == 1) pin_raw = ~pin_raw;
        end

        edges(2);
        done_all = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done_all) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule